// File: doc/BRIEF.md
# Global Timer with Periodic Comparator

This block is a memory-mapped system timer. It contains a 64-bit free-running counter and a single 64-bit comparator. Software reaches it over a simple 32-bit register bus with an address, a write enable, write data and combinational read data. The block drives one level interrupt output.

Software can load the counter and the comparator one 32-bit half at a time. Each half of the counter always reads back its live value. A wide value is read consistently by reading the high half, then the low half, then the high half again, and retrying until the two high reads agree.

When the comparator is enabled and equals the counter, a sticky interrupt status bit is set. In periodic mode the comparator then re-arms itself by adding a programmed 32-bit increment, so matches repeat at a fixed spacing. Every write to a counter, comparator, increment or control register is acknowledged through its own sticky write-status bit. That bit sets a fixed number of clock cycles after the write, which stands in for the synchronisation into a separate timer clock. Software clears it by writing 1.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the counter, comparator, increment, control, interrupt enable, interrupt status and all write-status bits read zero, and `irq` is low.
- R2: With control bit 8 (run) set, the counter advances by one on every clock. With it clear, the counter holds its value.
- R3: A write to 0x100 loads the low 32 bits of the counter and a write to 0x104 loads the high 32 bits. Reads of these two addresses return the live counter halves, which differ between reads taken one clock apart while the counter runs.
- R4: The counter wraps from all-ones to zero. The wrap sets no interrupt status and no write-status bit.
- R5: When control bit 0 (compare enable) is set and the counter equals the comparator (low half at 0x200, high half at 0x204), interrupt status bit 0 at 0x244 is set one clock later. It stays set until software clears it.
- R6: Writing 1 to bit 0 of 0x244 clears the interrupt status. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly when interrupt status bit 0 and interrupt enable bit 0 at 0x248 are both set. Clearing the enable does not clear the status.
- R8: With control bit 1 (auto-increment) set, each match adds the 32-bit increment at 0x208 to the comparator. With it clear, a match leaves the comparator unchanged.
- R9: At 0x24C, bit 16 acknowledges a control write (0x240), and bits 0, 1 and 2 acknowledge writes to the comparator low half, the comparator high half and the increment. Each bit reads 1 from the third clock after the write's own clock and not earlier.
- R10: At 0x110, bits 0 and 1 acknowledge writes to the counter low half and high half, with the same three-clock delay.
- R11: Write-status bits are sticky. Writing 1 to a bit clears only that bit, and the other bits keep their value.
- R12: With compare enable clear, no equality between counter and comparator sets the interrupt status.
- R13: The comparator halves, the increment, the control bits (8, 1, 0) and interrupt enable bit 0 read back as written, with the other bits zero. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (12) | Register byte address |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Combinational read data for `addr` |
| irq | output | 1 | Comparator interrupt (status AND enable) |

## Verification
A counter that skips or stalls shows up at the next read of 0x100, and an increment loaded at the wrong time gives a wrong second match. Both are visible within a clock of the fault. A comparator that re-arms wrongly moves the next status set away from its expected cycle, and the bench reads 0x200 and 0x244 on the exact clock after each match. A write-status pipe of the wrong length shows as a bit that is set one read early or one read late, because the bench polls 0x24C on every clock from the write onward. A sticky bit that clears by itself, or clears its neighbours, is seen on the next read of the register that holds it.

// File: rtl/stt_pkg.sv
package stt_pkg;

  // Register byte offsets (software decodes these)
  localparam int OFF_CNT_LO  = 'h100;
  localparam int OFF_CNT_HI  = 'h104;
  localparam int OFF_WS_CNT  = 'h110;
  localparam int OFF_CMP_LO  = 'h200;
  localparam int OFF_CMP_HI  = 'h204;
  localparam int OFF_INCR    = 'h208;
  localparam int OFF_CTRL    = 'h240;
  localparam int OFF_IRQ_ST  = 'h244;
  localparam int OFF_IRQ_EN  = 'h248;
  localparam int OFF_WS_CMP  = 'h24C;

  // Control field positions
  localparam int RUN_BIT   = 8;
  localparam int AUTO_BIT  = 1;
  localparam int CMPEN_BIT = 0;

  // Write-status field positions in the compare-group status register
  localparam int WS_CTRL_BIT = 16;

  // Write strobes from control to datapath
  typedef struct packed {
    logic ctrl;
    logic incr;
    logic cmpHi;
    logic cmpLo;
    logic cntHi;
    logic cntLo;
  } wrStrobe_t;

  localparam int NUM_TRACKED = $bits(wrStrobe_t);

endpackage

// File: rtl/stt_ctrl.sv
module stt_ctrl
  import stt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ACK_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [3:0]        wrFlags,   // {wrData[16], wrData[2:0]}
  input  logic              matchHit,
  output wrStrobe_t         stb,
  output logic              irqPend,
  output logic              irqEn,
  output logic [1:0]        wsCnt,
  output logic [3:0]        wsCmp
);

  logic                   hitStat, hitEn, hitWsCnt, hitWsCmp;
  logic                   clrIrq;
  logic [NUM_TRACKED-1:0] wrVec;
  logic [NUM_TRACKED-1:0] clrVec;
  logic [NUM_TRACKED-1:0] wsFlags;

  always_comb begin
    stb.cntLo = wrEn && (addr == ADDR_W'(OFF_CNT_LO));
    stb.cntHi = wrEn && (addr == ADDR_W'(OFF_CNT_HI));
    stb.cmpLo = wrEn && (addr == ADDR_W'(OFF_CMP_LO));
    stb.cmpHi = wrEn && (addr == ADDR_W'(OFF_CMP_HI));
    stb.incr  = wrEn && (addr == ADDR_W'(OFF_INCR));
    stb.ctrl  = wrEn && (addr == ADDR_W'(OFF_CTRL));
    hitStat   = wrEn && (addr == ADDR_W'(OFF_IRQ_ST));
    hitEn     = wrEn && (addr == ADDR_W'(OFF_IRQ_EN));
    hitWsCnt  = wrEn && (addr == ADDR_W'(OFF_WS_CNT));
    hitWsCmp  = wrEn && (addr == ADDR_W'(OFF_WS_CMP));
  end

  assign clrIrq = hitStat && wrFlags[0];

  // Interrupt status: a match wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend <= 1'b0;
      irqEn   <= 1'b0;
    end else begin
      if (matchHit)    irqPend <= 1'b1;
      else if (clrIrq) irqPend <= 1'b0;
      if (hitEn)       irqEn   <= wrFlags[0];
    end
  end

  // Channel order follows wrStrobe_t: cntLo, cntHi, cmpLo, cmpHi, incr, ctrl
  assign wrVec  = stb;
  assign clrVec = {hitWsCmp && wrFlags[3],
                   hitWsCmp && wrFlags[2],
                   hitWsCmp && wrFlags[1],
                   hitWsCmp && wrFlags[0],
                   hitWsCnt && wrFlags[1],
                   hitWsCnt && wrFlags[0]};

  // Write-acknowledge delay line per tracked register
  for (genvar ch = 0; ch < NUM_TRACKED; ch++) begin : g_ack
    logic [ACK_DELAY-1:0] ackPipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ackPipe     <= '0;
        wsFlags[ch] <= 1'b0;
      end else begin
        ackPipe[0] <= wrVec[ch];
        for (int i = 1; i < ACK_DELAY; i++) ackPipe[i] <= ackPipe[i-1];
        if (ackPipe[ACK_DELAY-1]) wsFlags[ch] <= 1'b1;
        else if (clrVec[ch])      wsFlags[ch] <= 1'b0;
      end
    end
  end

  assign wsCnt = wsFlags[1:0];
  assign wsCmp = wsFlags[5:2];

endmodule

// File: rtl/stt_datapath.sv
module stt_datapath
  import stt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  cmpVal,
  output logic [DATA_W-1:0] incrVal,
  output logic [2:0]        ctrlBits,  // {run, autoInc, cmpEn}
  output logic              matchHit
);

  logic run, autoInc, cmpEn;

  assign {run, autoInc, cmpEn} = ctrlBits;
  assign matchHit = cmpEn && (cntVal == cmpVal);

  // Free-running counter; a software load wins over counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntVal <= '0;
    else if (stb.cntLo) cntVal <= {cntVal[CNT_W-1:DATA_W], wrData};
    else if (stb.cntHi) cntVal <= {wrData, cntVal[DATA_W-1:0]};
    else if (run)       cntVal <= cntVal + CNT_W'(1);
  end

  // Comparator; a software load wins over the periodic re-arm
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cmpVal <= '0;
    else if (stb.cmpLo)            cmpVal <= {cmpVal[CNT_W-1:DATA_W], wrData};
    else if (stb.cmpHi)            cmpVal <= {wrData, cmpVal[DATA_W-1:0]};
    else if (matchHit && autoInc)  cmpVal <= cmpVal + CNT_W'(incrVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incrVal  <= '0;
      ctrlBits <= '0;
    end else begin
      if (stb.incr) incrVal  <= wrData;
      if (stb.ctrl) ctrlBits <= {wrData[RUN_BIT], wrData[AUTO_BIT], wrData[CMPEN_BIT]};
    end
  end

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import stt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int ACK_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int CNT_W = 2 * DATA_W;

  wrStrobe_t         stb;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  cmpVal;
  logic [DATA_W-1:0] incrVal;
  logic [2:0]        ctrlBits;
  logic              matchHit;
  logic              irqPend;
  logic              irqEn;
  logic [1:0]        wsCnt;
  logic [3:0]        wsCmp;

  stt_ctrl #(
    .ADDR_W   (ADDR_W),
    .ACK_DELAY(ACK_DELAY)
  ) ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .wrFlags ({wrData[WS_CTRL_BIT], wrData[2:0]}),
    .matchHit(matchHit),
    .stb     (stb),
    .irqPend (irqPend),
    .irqEn   (irqEn),
    .wsCnt   (wsCnt),
    .wsCmp   (wsCmp)
  );

  stt_datapath #(
    .DATA_W(DATA_W)
  ) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .cntVal  (cntVal),
    .cmpVal  (cmpVal),
    .incrVal (incrVal),
    .ctrlBits(ctrlBits),
    .matchHit(matchHit)
  );

  assign irq = irqPend && irqEn;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(OFF_CNT_LO): rdData = cntVal[DATA_W-1:0];
      ADDR_W'(OFF_CNT_HI): rdData = cntVal[CNT_W-1:DATA_W];
      ADDR_W'(OFF_WS_CNT): rdData[1:0] = wsCnt;
      ADDR_W'(OFF_CMP_LO): rdData = cmpVal[DATA_W-1:0];
      ADDR_W'(OFF_CMP_HI): rdData = cmpVal[CNT_W-1:DATA_W];
      ADDR_W'(OFF_INCR):   rdData = incrVal;
      ADDR_W'(OFF_CTRL): begin
        rdData[RUN_BIT]   = ctrlBits[2];
        rdData[AUTO_BIT]  = ctrlBits[1];
        rdData[CMPEN_BIT] = ctrlBits[0];
      end
      ADDR_W'(OFF_IRQ_ST): rdData[0] = irqPend;
      ADDR_W'(OFF_IRQ_EN): rdData[0] = irqEn;
      ADDR_W'(OFF_WS_CMP): begin
        rdData[WS_CTRL_BIT] = wsCmp[3];
        rdData[2:0]         = wsCmp[2:0];
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk
  import stt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int ACK_DELAY = 3,
  localparam int CNT_W    = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              clrIrqBit,
  input logic              clrCtrlWsBit,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  cmpVal,
  input logic [DATA_W-1:0] incrVal,
  input logic              running,
  input logic              autoInc,
  input logic              matchHit,
  input logic              irqPend,
  input logic              wsCtrlBit
);

  logic cntWr, cmpWr, ctrlWr, irqClr, ctrlWsClr;
  logic [ACK_DELAY-1:0] ctrlWrAge;

  assign cntWr     = wrEn && (addr == ADDR_W'(OFF_CNT_LO) || addr == ADDR_W'(OFF_CNT_HI));
  assign cmpWr     = wrEn && (addr == ADDR_W'(OFF_CMP_LO) || addr == ADDR_W'(OFF_CMP_HI));
  assign ctrlWr    = wrEn && (addr == ADDR_W'(OFF_CTRL));
  assign irqClr    = wrEn && (addr == ADDR_W'(OFF_IRQ_ST)) && clrIrqBit;
  assign ctrlWsClr = wrEn && (addr == ADDR_W'(OFF_WS_CMP)) && clrCtrlWsBit;

  // Age of control writes, used to bound the acknowledge window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlWrAge <= '0;
    else begin
      ctrlWrAge[0] <= ctrlWr;
      for (int i = 1; i < ACK_DELAY; i++) ctrlWrAge[i] <= ctrlWrAge[i-1];
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !cntWr) |=> cntVal == $past(cntVal) + CNT_W'(1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cntWr) |=> $stable(cntVal));

  // R5
  match_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> irqPend);

  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !matchHit) |=> !irqPend);

  // R8
  periodic_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && autoInc && !cmpWr) |=> cmpVal == $past(cmpVal) + CNT_W'($past(incrVal)));

  // R9
  ctrl_ack_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wsCtrlBit) |-> $past(ctrlWrAge[ACK_DELAY-1]));

  // R11
  ctrl_ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWsClr && !ctrlWrAge[ACK_DELAY-1]) |=> !wsCtrlBit);

endmodule

bind sys_tick_timer sys_tick_timer_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .ACK_DELAY(ACK_DELAY)
) chkInst (
  .clk         (clk),
  .rstN        (rstN),
  .addr        (addr),
  .wrEn        (wrEn),
  .clrIrqBit   (wrData[0]),
  .clrCtrlWsBit(wrData[16]),
  .cntVal      (cntVal),
  .cmpVal      (cmpVal),
  .incrVal     (incrVal),
  .running     (ctrlBits[2]),
  .autoInc     (ctrlBits[1]),
  .matchHit    (matchHit),
  .irqPend     (irqPend),
  .wsCtrlBit   (wsCmp[3])
);

// File: tb/sys_tick_timer_test.sv
`timescale 1ns/100ps
module sys_tick_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sys_tick_timer uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // {req id, address, write data, expected readback}
  localparam logic [79:0] VEC [9] = '{
    {4'd13, 12'h200, 32'h1111_2222, 32'h1111_2222},
    {4'd13, 12'h204, 32'h3333_4444, 32'h3333_4444},
    {4'd13, 12'h208, 32'h0000_0010, 32'h0000_0010},
    {4'd13, 12'h248, 32'hFFFF_FFFF, 32'h0000_0001},
    {4'd13, 12'h240, 32'hFFFF_FEFE, 32'h0000_0002},
    {4'd3,  12'h104, 32'h0000_00AB, 32'h0000_00AB},
    {4'd3,  12'h100, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {4'd13, 12'h248, 32'h0000_0000, 32'h0000_0000},
    {4'd13, 12'h300, 32'h5A5A_5A5A, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #0.4;
    d = rdData;
  endtask

  task automatic clearAcks();
    repeat (5) @(negedge clk);
    wr(12'h110, 32'h3);
    wr(12'h24C, 32'h0001_0007);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(12'h100, v); check("R1 cnt lo", v, 0);
    rd(12'h104, v); check("R1 cnt hi", v, 0);
    rd(12'h240, v); check("R1 ctrl", v, 0);
    rd(12'h244, v); check("R1 status", v, 0);
    @(negedge clk);
    rd(12'h110, v); check("R1 ws cnt", v, 0);
    rd(12'h24C, v); check("R1 ws cmp", v, 0);
    rd(12'h200, v); check("R1 cmp", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // Table of register writes and readbacks (R3, R13)
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], v);
      tests++;
      if (v !== VEC[i][31:0]) begin
        fails++;
        $display("FAIL R%0d vec %0d: actual %h expected %h", VEC[i][79:76], i, v, VEC[i][31:0]);
      end
    end
    rd(12'h104, v); check("R3 hi kept after lo load", v, 32'hAB);

    // R10 counter acknowledges, R11 per-bit clear
    repeat (4) @(negedge clk);
    rd(12'h110, v); check("R10 counter acks", v, 32'h3);
    wr(12'h110, 32'h2);
    rd(12'h110, v); check("R11 clear hi ack only", v, 32'h1);
    rd(12'h24C, v); check("R9 acks from table", v, 32'h0001_0007);
    clearAcks();
    rd(12'h24C, v); check("R11 cmp acks cleared", v, 0);
    rd(12'h110, v); check("R11 cnt acks cleared", v, 0);

    // R9 three-clock acknowledge of an increment write
    wr(12'h208, 32'h7);
    rd(12'h24C, v); check("R9 ack +0", v, 0);
    @(negedge clk); rd(12'h24C, v); check("R9 ack +1", v, 0);
    @(negedge clk); rd(12'h24C, v); check("R9 ack +2", v, 0);
    @(negedge clk); rd(12'h24C, v); check("R9 ack +3", v, 32'h4);
    wr(12'h24C, 32'h4);
    rd(12'h24C, v); check("R11 incr ack cleared", v, 0);
    wr(12'h200, 32'h0);
    wr(12'h240, 32'h0);
    repeat (4) @(negedge clk);
    rd(12'h24C, v); check("R9 ctrl and cmp lo acks", v, 32'h0001_0001);
    wr(12'h24C, 32'h1);
    rd(12'h24C, v); check("R11 ctrl ack survives", v, 32'h0001_0000);

    // R2 counting, R3 live reads
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    wr(12'h240, 32'h100);
    repeat (10) @(negedge clk);
    rd(12'h100, v); check("R2 count after 10", v, 32'd10);
    @(negedge clk);
    rd(12'h100, v); check("R3 live lo", v, 32'd11);
    rd(12'h104, v); check("R3 live hi", v, 0);
    wr(12'h240, 32'h0);
    rd(12'h100, v); check("R2 stop value", v, 32'd13);
    repeat (5) @(negedge clk);
    rd(12'h100, v); check("R2 hold", v, 32'd13);

    // R4 wrap
    wr(12'h100, 32'hFFFF_FFFE);
    wr(12'h104, 32'hFFFF_FFFF);
    clearAcks();
    wr(12'h240, 32'h100);
    repeat (2) @(negedge clk);
    rd(12'h100, v); check("R4 wrap lo", v, 0);
    rd(12'h104, v); check("R4 wrap hi", v, 0);
    rd(12'h244, v); check("R4 no status", v, 0);
    rd(12'h110, v); check("R4 no ack", v, 0);

    // R5 / R7 / R8 one-shot match
    wr(12'h240, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    wr(12'h200, 32'd20);
    wr(12'h204, 32'h0);
    wr(12'h248, 32'h1);
    wr(12'h244, 32'h1);
    wr(12'h240, 32'h101);
    repeat (20) @(negedge clk);
    rd(12'h244, v); check("R5 not before match", v, 0);
    check("R7 irq low before match", {31'b0, irq}, 0);
    @(negedge clk);
    rd(12'h244, v); check("R5 status after match", v, 1);
    check("R7 irq high", {31'b0, irq}, 1);
    rd(12'h200, v); check("R8 one-shot cmp unchanged", v, 32'd20);
    repeat (10) @(negedge clk);
    rd(12'h244, v); check("R5 sticky", v, 1);
    wr(12'h248, 32'h0);
    check("R7 irq masked", {31'b0, irq}, 0);
    rd(12'h244, v); check("R7 status kept when masked", v, 1);
    wr(12'h244, 32'h0);
    rd(12'h244, v); check("R6 write 0 no effect", v, 1);
    wr(12'h244, 32'h1);
    rd(12'h244, v); check("R6 write 1 clears", v, 0);
    wr(12'h248, 32'h1);

    // R8 periodic re-arm
    wr(12'h240, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h200, 32'd10);
    wr(12'h208, 32'd7);
    wr(12'h244, 32'h1);
    wr(12'h240, 32'h103);
    repeat (11) @(negedge clk);
    rd(12'h200, v); check("R8 first re-arm", v, 32'd17);
    rd(12'h244, v); check("R5 periodic first match", v, 1);
    wr(12'h244, 32'h1);
    rd(12'h244, v); check("R6 cleared between matches", v, 0);
    repeat (5) @(negedge clk);
    rd(12'h244, v); check("R8 second match", v, 1);
    rd(12'h200, v); check("R8 second re-arm", v, 32'd24);

    // R12 compare disabled
    wr(12'h240, 32'h0);
    wr(12'h244, 32'h1);
    wr(12'h100, 32'h0);
    wr(12'h200, 32'd5);
    wr(12'h240, 32'h100);
    repeat (10) @(negedge clk);
    rd(12'h244, v); check("R12 no match when disabled", v, 0);
    check("R12 irq low", {31'b0, irq}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule